// File: doc/BRIEF.md
# DDR Command Pattern Sequencer

This block drives a repeating stream of DDR SDRAM commands of the kind used to measure a memory's operating current. It produces one command slot per clock, and it loops forever. Each slot carries a command code, a bank number, a row and column address and a 16-bit write-data word. The bench or tester that sits downstream turns these slots into pin activity. The sequencer itself knows nothing about the physical interface, strobes, initialisation or refresh.

There are two schedules. The single-bank loop opens bank 0, reads it once the row-to-column delay has passed, and closes it once the minimum active time has passed. The loop then repeats at the row-cycle period. The four-bank loop opens the banks two clocks apart, and after each opening it reads the bank opened one step earlier with auto-precharge. One of three speed-grade presets supplies the timing.

Between commands the bus carries deselects. The address takes a new pseudo-random value once per loop. The data word flips exactly half of its bits every clock.

Top module: `ddrpat_seq`

## Requirements
- R1: While `rst` is high and on the clock that releases it, the outputs are idle. That means command DESELECT, bank 0, data 0, and row and column taken from the seed 0xACE1. The first clock edge with `rst` low starts loop cycle 0.
- R2: With `quad_i`=0, the loop lasts tRC clocks. It issues ACTIVATE to bank 0 in cycle 0, READ in cycle tRCD and PRECHARGE in cycle tRAS, and DESELECT in every other cycle. The presets are (tRCD, tRAS, tRC) = (3, 7, 10) for grade 0 and grade 3, (3, 8, 11) for grade 1, and (4, 10, 13) for grade 2.
- R3: With `quad_i`=1 and grade 0, 1 or 3, the loop is 10 clocks long. By cycle it reads ACT b0, DES, ACT b1, RDAP b0, ACT b2, RDAP b1, ACT b3, RDAP b2, DES, RDAP b3.
- R4: With `quad_i`=1 and grade 2, one extra DESELECT follows the first activate. The loop is then 11 clocks long.
- R5: No two ACTIVATE commands, to any banks, are on adjacent clocks.
- R6: A read to a bank comes at least 3 clocks after that bank's activate. A PRECHARGE comes at least 7 clocks after the activate.
- R7: Row and column hold for a whole loop. They change only at loop cycle 0. The source is a 16-bit shift register that shifts left and feeds bit 0 with s[15]^s[13]^s[12]^s[10]. It starts from 0xACE1 and steps once per completed loop. The row is s[ROW_W-1:0] and the column is s[15:16-COL_W].
- R8: From 0 at loop cycle 0 after reset, the data word is XORed on every clock with a mask. The mask alternates between 0x00FF and 0xFF00, with 0x00FF first. Exactly 8 bits therefore change on every clock.
- R9: `quad_i` and `grade_i` are sampled only on the clock edge that ends a loop, or on the edge that starts the first loop. Changes at any other time have no effect on the loop in progress.
- R10: The command codes are DESELECT=0, ACTIVATE=1, READ=2, READ with auto-precharge=3 and PRECHARGE=4. No other code appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| quad_i | input | 1 | 0 = single-bank loop, 1 = four-bank loop |
| grade_i | input | 2 | Speed-grade preset select |
| cmd_o | output | 3 | Command code of the current slot |
| bank_o | output | 2 | Bank of the current slot |
| row_o | output | ROW_W | Row address for this loop |
| col_o | output | COL_W | Column address for this loop |
| data_o | output | DATA_W | Write-data pattern |

## Verification
A cycle counter or latched configuration that drifts shows at the ports immediately. The cause can be a wrong loop length, a wrong preset, or a mode taken up mid-loop. In each case a command lands in the wrong slot or on the wrong bank on the very next clock where the expected stream has a non-deselect. At the latest, the slip shows on the following loop's activate. A stuck or mis-stepped address register shows at the next loop's cycle 0. Each loop's row and column are compared with an independently stepped reference. A lost toggle phase breaks the half-word flip within one clock. The bench also measures the activate-to-activate, activate-to-read and activate-to-precharge distances on the live stream, independently of the expected tables.

// File: rtl/ddrpat_pkg.sv
package ddrpat_pkg;

    localparam int CYC_W  = 4;
    localparam int LFSR_W = 16;

    typedef enum logic [2:0] {
        CMD_DESEL = 3'd0,
        CMD_ACT   = 3'd1,
        CMD_RD    = 3'd2,
        CMD_RDAP  = 3'd3,
        CMD_PRE   = 3'd4
    } cmd_e;

    typedef struct packed {
        logic [CYC_W-1:0] rcd;
        logic [CYC_W-1:0] ras;
        logic [CYC_W-1:0] rc;
    } tim_t;

    typedef struct packed {
        logic       quad;
        logic [1:0] grade;
    } cfg_t;

    typedef struct packed {
        cmd_e       cmd;
        logic [1:0] bank;
    } slot_t;

    // Speed-grade presets; code 3 falls back to the fastest set.
    function automatic tim_t preset(input logic [1:0] grade);
        tim_t t;
        case (grade)
            2'd1:    t = '{rcd: 4'd3, ras: 4'd8,  rc: 4'd11};
            2'd2:    t = '{rcd: 4'd4, ras: 4'd10, rc: 4'd13};
            default: t = '{rcd: 4'd3, ras: 4'd7,  rc: 4'd10};
        endcase
        return t;
    endfunction

    // Four-bank loop gains one slot after the first activate for grade 2.
    function automatic logic quad_skew(input logic [1:0] grade);
        return grade == 2'd2;
    endfunction

    function automatic logic [CYC_W-1:0] loop_len(input cfg_t cfg);
        if (cfg.quad)
            return CYC_W'(10) + CYC_W'(quad_skew(cfg.grade));
        return preset(cfg.grade).rc;
    endfunction

    function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
        return {s[LFSR_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

endpackage

// File: rtl/ddrpat_lfsr.sv
module ddrpat_lfsr
    import ddrpat_pkg::*;
#(
    parameter logic [LFSR_W-1:0] SEED = 16'hACE1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adv,
    output logic [LFSR_W-1:0] state
);
    always_ff @(posedge clk) begin
        if (rst)
            state <= SEED;
        else if (adv)
            state <= lfsr_step(state);
    end
endmodule

// File: rtl/ddrpat_sched.sv
module ddrpat_sched
    import ddrpat_pkg::*;
(
    input  cfg_t             cfg,
    input  logic [CYC_W-1:0] cyc,
    output slot_t            slot,
    output logic             last
);
    tim_t             tim;
    logic             skew;
    logic [CYC_W-1:0] d;

    always_comb begin
        tim  = preset(cfg.grade);
        skew = quad_skew(cfg.grade);
        d    = cyc - CYC_W'(skew);
        slot = '{cmd: CMD_DESEL, bank: 2'd0};
        if (cyc == '0) begin
            slot = '{cmd: CMD_ACT, bank: 2'd0};
        end else if (!cfg.quad) begin
            if (cyc == tim.rcd)
                slot = '{cmd: CMD_RD, bank: 2'd0};
            else if (cyc == tim.ras)
                slot = '{cmd: CMD_PRE, bank: 2'd0};
        end else if (cyc > CYC_W'(skew)) begin
            case (d)
                4'd2, 4'd4, 4'd6: slot = '{cmd: CMD_ACT,  bank: d[2:1]};
                4'd3, 4'd5, 4'd7: slot = '{cmd: CMD_RDAP, bank: 2'((d - 4'd3) >> 1)};
                4'd9:             slot = '{cmd: CMD_RDAP, bank: 2'd3};
                default:          slot = '{cmd: CMD_DESEL, bank: 2'd0};
            endcase
        end
        last = (cyc == loop_len(cfg) - 4'd1);
    end
endmodule

// File: rtl/ddrpat_toggle.sv
module ddrpat_toggle #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adv,
    output logic [DATA_W-1:0] data
);
    localparam int HALF = DATA_W / 2;
    localparam logic [DATA_W-1:0] MASK_LO = {{HALF{1'b0}}, {HALF{1'b1}}};
    localparam logic [DATA_W-1:0] MASK_HI = ~MASK_LO;

    logic phase;

    always_ff @(posedge clk) begin
        if (rst) begin
            data  <= '0;
            phase <= 1'b0;
        end else if (adv) begin
            data  <= data ^ (phase ? MASK_HI : MASK_LO);
            phase <= ~phase;
        end
    end
endmodule

// File: rtl/ddrpat_seq.sv
module ddrpat_seq
    import ddrpat_pkg::*;
#(
    parameter int                ROW_W  = 12,
    parameter int                COL_W  = 10,
    parameter int                DATA_W = 16,
    parameter logic [LFSR_W-1:0] SEED   = 16'hACE1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              quad_i,
    input  logic [1:0]        grade_i,
    output logic [2:0]        cmd_o,
    output logic [1:0]        bank_o,
    output logic [ROW_W-1:0]  row_o,
    output logic [COL_W-1:0]  col_o,
    output logic [DATA_W-1:0] data_o
);
    logic             run_q;
    logic [CYC_W-1:0] cyc_q;
    cfg_t             cfg_q;
    slot_t            slot;
    logic             last;
    logic [LFSR_W-1:0] addr_state;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 1'b0;
            cyc_q <= '0;
            cfg_q <= '{quad: quad_i, grade: grade_i};
        end else if (!run_q || last) begin
            run_q <= 1'b1;
            cyc_q <= '0;
            cfg_q <= '{quad: quad_i, grade: grade_i};
        end else begin
            cyc_q <= cyc_q + 4'd1;
        end
    end

    ddrpat_sched u_sched (
        .cfg  (cfg_q),
        .cyc  (cyc_q),
        .slot (slot),
        .last (last)
    );

    ddrpat_lfsr #(.SEED(SEED)) u_lfsr (
        .clk   (clk),
        .rst   (rst),
        .adv   (run_q && last),
        .state (addr_state)
    );

    ddrpat_toggle #(.DATA_W(DATA_W)) u_toggle (
        .clk  (clk),
        .rst  (rst),
        .adv  (run_q),
        .data (data_o)
    );

    assign cmd_o  = run_q ? slot.cmd  : CMD_DESEL;
    assign bank_o = run_q ? slot.bank : 2'd0;
    assign row_o  = addr_state[ROW_W-1:0];
    assign col_o  = addr_state[LFSR_W-1 -: COL_W];
endmodule

// File: rtl/ddrpat_seq_chk.sv
module ddrpat_seq_chk
    import ddrpat_pkg::*;
#(
    parameter int ROW_W  = 12,
    parameter int COL_W  = 10,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic [2:0]        cmd,
    input logic [1:0]        bank,
    input logic [ROW_W-1:0]  row,
    input logic [COL_W-1:0]  col,
    input logic [DATA_W-1:0] data,
    input logic              run,
    input logic [CYC_W-1:0]  cyc,
    input cfg_t              cfg
);
    logic [3:0] since [4];

    for (genvar b = 0; b < 4; b++) begin : g_bank
        always_ff @(posedge clk) begin
            if (rst)
                since[b] <= 4'd0;
            else if (cmd == CMD_ACT && bank == 2'(b))
                since[b] <= 4'd1;
            else if (since[b] != 4'd0 && since[b] != 4'd15)
                since[b] <= since[b] + 4'd1;
        end

        // R6: read no sooner than 3 clocks after the bank's activate
        a_r6_read_gap: assert property (@(posedge clk) disable iff (rst)
            ((cmd == CMD_RD || cmd == CMD_RDAP) && bank == 2'(b)) |-> since[b] >= 4'd3);
        // R6: precharge no sooner than 7 clocks after activate
        a_r6_pre_gap: assert property (@(posedge clk) disable iff (rst)
            (cmd == CMD_PRE && bank == 2'(b)) |-> since[b] >= 4'd7);
    end

    a_r5_act_spacing: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_ACT) |=> (cmd != CMD_ACT));

    a_r2_pre_then_idle: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_PRE) |=> (cmd == CMD_DESEL));

    a_r8_half_toggle: assert property (@(posedge clk) disable iff (rst)
        run |=> ($countones(data ^ $past(data)) == DATA_W / 2));

    a_r7_addr_hold: assert property (@(posedge clk) disable iff (rst)
        (run && cyc != '0) |-> ($stable(row) && $stable(col)));

    a_r9_cfg_hold: assert property (@(posedge clk) disable iff (rst)
        (run && cyc != '0) |-> $stable(cfg));

    a_r10_cmd_legal: assert property (@(posedge clk) disable iff (rst)
        cmd <= 3'd4);

    a_r1_idle_out: assert property (@(posedge clk) disable iff (1'b0)
        rst |=> (cmd == CMD_DESEL && data == '0));
endmodule

bind ddrpat_seq ddrpat_seq_chk #(
    .ROW_W  (ROW_W),
    .COL_W  (COL_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk  (clk),
    .rst  (rst),
    .cmd  (cmd_o),
    .bank (bank_o),
    .row  (row_o),
    .col  (col_o),
    .data (data_o),
    .run  (run_q),
    .cyc  (cyc_q),
    .cfg  (cfg_q)
);

// File: tb/ddrpat_seq_bench.sv
module ddrpat_seq_bench;
    localparam int ROW_W  = 12;
    localparam int COL_W  = 10;
    localparam int DATA_W = 16;
    localparam logic [15:0] SEED = 16'hACE1;

    // {cmd[2:0], bank[1:0]} per cycle for the four-bank loops (R3, R4)
    localparam logic [4:0] QAB [10] = '{5'b001_00, 5'b000_00, 5'b001_01, 5'b011_00,
        5'b001_10, 5'b011_01, 5'b001_11, 5'b011_10, 5'b000_00, 5'b011_11};
    localparam logic [4:0] QC  [11] = '{5'b001_00, 5'b000_00, 5'b000_00, 5'b001_01,
        5'b011_00, 5'b001_10, 5'b011_01, 5'b001_11, 5'b011_10, 5'b000_00, 5'b011_11};
    // Vector table: {quad, grade}
    localparam logic [2:0] VEC [7] = '{3'b0_00, 3'b0_01, 3'b0_10, 3'b0_11,
                                       3'b1_00, 3'b1_01, 3'b1_10};

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              quad_i = 1'b0;
    logic [1:0]        grade_i = 2'd0;
    logic [2:0]        cmd_o;
    logic [1:0]        bank_o;
    logic [ROW_W-1:0]  row_o;
    logic [COL_W-1:0]  col_o;
    logic [DATA_W-1:0] data_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [15:0] ref_lfsr;
    int ref_n;

    always #4 clk = ~clk;

    ddrpat_seq u_ddrpat_seq (
        .clk(clk), .rst(rst), .quad_i(quad_i), .grade_i(grade_i),
        .cmd_o(cmd_o), .bank_o(bank_o), .row_o(row_o), .col_o(col_o), .data_o(data_o)
    );

    function automatic logic [15:0] lf_next(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    function automatic int exp_len(input logic q, input logic [1:0] g);
        if (q) return (g == 2'd2) ? 11 : 10;
        case (g)
            2'd1: return 11;
            2'd2: return 13;
            default: return 10;
        endcase
    endfunction

    function automatic logic [4:0] exp_slot(input logic q, input logic [1:0] g, input int c);
        int rcd, ras;
        if (q) return (g == 2'd2) ? QC[c] : QAB[c];
        rcd = (g == 2'd2) ? 4 : 3;
        ras = (g == 2'd1) ? 8 : (g == 2'd2) ? 10 : 7;
        if (c == 0)   return 5'b001_00;
        if (c == rcd) return 5'b010_00;
        if (c == ras) return 5'b100_00;
        return 5'b000_00;
    endfunction

    function automatic logic [15:0] exp_data(input int n);
        case (n % 4)
            1: return 16'h00FF;
            2: return 16'hFFFF;
            3: return 16'hFF00;
            default: return 16'h0000;
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Reset with the given inputs, check the idle state (R1), release.
    task automatic do_reset(input logic q, input logic [1:0] g);
        @(negedge clk);
        rst = 1'b1; quad_i = q; grade_i = g;
        repeat (3) @(negedge clk);
        check(cmd_o == 3'd0, "R1 idle cmd", 32'(cmd_o), 0);
        check(data_o == '0, "R1 idle data", 32'(data_o), 0);
        check(row_o == SEED[ROW_W-1:0], "R1 seed row", 32'(row_o), 32'(SEED[ROW_W-1:0]));
        rst = 1'b0;
        @(negedge clk);
        ref_lfsr = SEED;
        ref_n = 0;
    endtask

    // Walk one loop from cycle 0; optionally change inputs after sampling cycle chg.
    task automatic check_loop(input logic q, input logic [1:0] g, input string tag,
                              input int chg, input logic nq, input logic [1:0] ng);
        int len;
        logic [4:0] e;
        len = exp_len(q, g);
        for (int c = 0; c < len; c++) begin
            e = exp_slot(q, g, c);
            check({cmd_o, bank_o} == e, tag, 32'({cmd_o, bank_o}), 32'(e));
            check(row_o == ref_lfsr[ROW_W-1:0] && col_o == ref_lfsr[15 -: COL_W],
                  "R7 address", 32'({row_o, col_o}),
                  32'({ref_lfsr[ROW_W-1:0], ref_lfsr[15 -: COL_W]}));
            check(data_o == exp_data(ref_n), "R8 data", 32'(data_o), 32'(exp_data(ref_n)));
            if (c == chg) begin
                quad_i = nq; grade_i = ng;
            end
            @(negedge clk);
            ref_n++;
        end
        ref_lfsr = lf_next(ref_lfsr);
    endtask

    // Live-stream timing monitor (R5, R6)
    int gcyc, last_act;
    int act_t [4];
    bit had_act;
    always @(negedge clk) begin
        if (rst) begin
            had_act = 1'b0; gcyc = 0;
            for (int b = 0; b < 4; b++) act_t[b] = -100;
        end else begin
            gcyc++;
            if (cmd_o == 3'd1) begin
                if (had_act)
                    check(gcyc - last_act >= 2, "R5 act spacing", 32'(gcyc - last_act), 2);
                had_act = 1'b1; last_act = gcyc; act_t[bank_o] = gcyc;
            end else if (cmd_o == 3'd2 || cmd_o == 3'd3) begin
                check(gcyc - act_t[bank_o] >= 3, "R6 read gap", 32'(gcyc - act_t[bank_o]), 3);
            end else if (cmd_o == 3'd4) begin
                check(gcyc - act_t[bank_o] >= 7, "R6 pre gap", 32'(gcyc - act_t[bank_o]), 7);
            end
        end
    end

    initial begin
        for (int v = 0; v < 7; v++) begin
            logic q;
            logic [1:0] g;
            string tag;
            q = VEC[v][2]; g = VEC[v][1:0];
            tag = !q ? "R2 R10 single slot" : (g == 2'd2) ? "R4 R10 quad slot" : "R3 R10 quad slot";
            do_reset(q, g);
            check_loop(q, g, tag, -1, q, g);
            check_loop(q, g, tag, -1, q, g);
        end
        // R9: mid-loop change ignored, boundary change taken up
        do_reset(1'b0, 2'd0);
        check_loop(1'b0, 2'd0, "R9 hold single A", 2, 1'b1, 2'd2);
        check_loop(1'b1, 2'd2, "R9 quad C after boundary", 10, 1'b0, 2'd1);
        check_loop(1'b0, 2'd1, "R9 single B after boundary", 4, 1'b1, 2'd0);
        check_loop(1'b1, 2'd0, "R9 quad A", -1, 1'b1, 2'd0);
        // R1: reset mid-run restarts at cycle 0 with the seed
        repeat (3) @(negedge clk);
        do_reset(1'b0, 2'd2);
        check_loop(1'b0, 2'd2, "R1 restart", -1, 1'b0, 2'd2);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule